// File: doc/BRIEF.md
# Floating-Point Operand Wait Station

This block holds a small pool of pending operations for a single floating-point execution unit. An issue stage writes an operation into a free slot. Each source operand arrives in one of two forms: a finished value, or the reorder-buffer tag of the older instruction that will produce it. Each slot also records the reorder-buffer tag that names its own result.

Slots that are missing an operand watch the common result bus. When the bus tag equals the awaited tag, the slot takes the bus data. A slot becomes eligible to start once it holds values for both operands. One eligible slot per cycle is sent to the execution unit, and the lowest index wins.

A slot that has been sent stays occupied until the result bus carries its own destination tag, and only then can it be reused. A flush input empties the whole pool in one cycle after a branch misprediction.

Top module: `fp_rsv_station`

## Requirements
- R1: After synchronous reset, `iss_ready` is 1 and `disp_valid` is 0.
- R2: An issue (`iss_valid`=1) is taken only when `iss_ready` is 1. `iss_ready` is 0 exactly when all NUM slots are occupied. An issue offered while `iss_ready` is 0 leaves no trace and never dispatches.
- R3: An operand marked ready at issue (`iss_x_rdy`=1) keeps its value. A slot whose operands are both ready at issue dispatches in the next cycle. It presents the issued op code, both values and the destination tag on `disp_*`.
- R4: An operand issued with `iss_x_rdy`=0 waits on `iss_x_tag`. It takes `cdb_data` in a cycle where `cdb_valid`=1 and `cdb_tag` equals that tag. Broadcasts carrying any other tag leave it waiting.
- R5: If, in the cycle of issue, the result bus already carries the tag of a waiting operand, that operand is stored as the bus value.
- R6: A slot never dispatches while either operand is still waiting. The earliest dispatch is the cycle after the last operand is captured.
- R7: At most one slot dispatches per cycle. When several slots are eligible, the lowest-indexed one goes first, and the rest follow in later cycles.
- R8: A dispatched slot is not dispatched again. It stays occupied until a broadcast carries its destination tag, and broadcasts with other tags do not free it. A freed slot can accept a new issue in the next cycle.
- R9: `flush`=1 frees every slot by the next cycle. Slots emptied this way never dispatch, even if their awaited tags are broadcast afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| flush | input | 1 | Empty all slots (misprediction recovery) |
| iss_valid | input | 1 | Issue request |
| iss_ready | output | 1 | At least one slot is free |
| iss_op | input | OP_W | Operation code |
| iss_a_rdy | input | 1 | Operand A is a value |
| iss_a_val | input | DATA_W | Operand A value |
| iss_a_tag | input | TAG_W | Producer tag of operand A |
| iss_b_rdy | input | 1 | Operand B is a value |
| iss_b_val | input | DATA_W | Operand B value |
| iss_b_tag | input | TAG_W | Producer tag of operand B |
| iss_dst | input | TAG_W | Reorder-buffer tag of the result |
| cdb_valid | input | 1 | Result bus carries a result |
| cdb_tag | input | TAG_W | Tag of the broadcast result |
| cdb_data | input | DATA_W | Broadcast result value |
| disp_valid | output | 1 | An operation is sent this cycle |
| disp_op | output | OP_W | Operation code sent |
| disp_a | output | DATA_W | Operand A sent |
| disp_b | output | DATA_W | Operand B sent |
| disp_dst | output | TAG_W | Destination tag sent |

## Verification
The bench's checks are timed to the ports, so an error inside a slot shows up within a cycle or two of the event that caused it. If a slot captures a bus value on the wrong tag, `disp_a` carries wrong data, or the slot dispatches one cycle early. A lost launched flag shows as a second `disp_valid` pulse with the same destination tag in the following cycle. A slot that is freed too early or too late shows on `iss_ready` in the cycle after the releasing broadcast. A flush that leaves a slot alive is caught by a `disp_valid` pulse after the slot's stale tag is broadcast.

// File: rtl/rsv_pkg.sv
// Shared definitions for the operand wait station.
// Assumes: nothing beyond IEEE 1800-2017 packages.
package rsv_pkg;

    // Slot life cycle: empty, holding (waiting or eligible), sent and awaiting result
    typedef enum logic [1:0] {
        SLOT_FREE = 2'd0,
        SLOT_HELD = 2'd1,
        SLOT_SENT = 2'd2
    } slot_state_t;

    localparam int DEF_SLOTS  = 3;
    localparam int DEF_DATA_W = 64;
    localparam int DEF_TAG_W  = 3;
    localparam int DEF_OP_W   = 4;

endpackage

// File: rtl/rsv_prio.sv
// Fixed-priority picker: grants the lowest-indexed set request.
// Assumes: purely combinational, N >= 1.
module rsv_prio #(
    parameter int N = 3
) (
    input  logic [N-1:0] req,
    output logic [N-1:0] grant,
    output logic         any
);

    // Walk upward and keep only the first request found
    always_comb begin
        logic found;
        found = 1'b0;
        grant = '0;
        for (int i = 0; i < N; i++) begin
            if (req[i] && !found) begin
                grant[i] = 1'b1;
                found    = 1'b1;
            end
        end
        any = |req;
    end

endmodule

// File: rtl/rsv_slot.sv
// One wait-station slot. It holds an op code, two operands (each a value or a
// producer tag) and a destination tag, snoops the result bus, and reports when
// both operands hold values.
// Assumes: alloc only pulses while the slot is free; launch only while eligible.
module rsv_slot
    import rsv_pkg::*;
#(
    parameter int DATA_W = DEF_DATA_W,
    parameter int TAG_W  = DEF_TAG_W,
    parameter int OP_W   = DEF_OP_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic              alloc,
    input  logic [OP_W-1:0]   iss_op,
    input  logic              iss_a_rdy,
    input  logic [DATA_W-1:0] iss_a_val,
    input  logic [TAG_W-1:0]  iss_a_tag,
    input  logic              iss_b_rdy,
    input  logic [DATA_W-1:0] iss_b_val,
    input  logic [TAG_W-1:0]  iss_b_tag,
    input  logic [TAG_W-1:0]  iss_dst,
    input  logic              cdb_valid,
    input  logic [TAG_W-1:0]  cdb_tag,
    input  logic [DATA_W-1:0] cdb_data,
    input  logic              launch,
    output logic              busy,
    output logic              eligible,
    output logic [OP_W-1:0]   op_q,
    output logic [DATA_W-1:0] a_q,
    output logic [DATA_W-1:0] b_q,
    output logic [TAG_W-1:0]  dst_q
);

    slot_state_t       state;
    logic              a_ok, b_ok;
    logic [TAG_W-1:0]  a_tag, b_tag;
    logic              a_hit_iss, b_hit_iss;
    logic              a_hit_bus, b_hit_bus, own_hit;

    // Tag comparisons against the bus, for issue-time bypass and for snooping
    always_comb begin
        a_hit_iss = cdb_valid && (cdb_tag == iss_a_tag);
        b_hit_iss = cdb_valid && (cdb_tag == iss_b_tag);
        a_hit_bus = cdb_valid && !a_ok && (cdb_tag == a_tag);
        b_hit_bus = cdb_valid && !b_ok && (cdb_tag == b_tag);
        own_hit   = cdb_valid && (cdb_tag == dst_q);
    end

    // Slot state: fill at issue, capture operands, mark sent, free on own result
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            state <= SLOT_FREE;
            a_ok  <= 1'b0;
            b_ok  <= 1'b0;
            a_tag <= '0;
            b_tag <= '0;
            a_q   <= '0;
            b_q   <= '0;
            op_q  <= '0;
            dst_q <= '0;
        end else if (alloc) begin
            state <= SLOT_HELD;
            op_q  <= iss_op;
            dst_q <= iss_dst;
            a_tag <= iss_a_tag;
            b_tag <= iss_b_tag;
            if (iss_a_rdy) begin
                a_q <= iss_a_val; a_ok <= 1'b1;
            end else if (a_hit_iss) begin
                a_q <= cdb_data;  a_ok <= 1'b1;
            end else begin
                a_q <= '0;        a_ok <= 1'b0;
            end
            if (iss_b_rdy) begin
                b_q <= iss_b_val; b_ok <= 1'b1;
            end else if (b_hit_iss) begin
                b_q <= cdb_data;  b_ok <= 1'b1;
            end else begin
                b_q <= '0;        b_ok <= 1'b0;
            end
        end else begin
            case (state)
                SLOT_HELD: begin
                    if (a_hit_bus) begin
                        a_q <= cdb_data; a_ok <= 1'b1;
                    end
                    if (b_hit_bus) begin
                        b_q <= cdb_data; b_ok <= 1'b1;
                    end
                    if (launch) state <= SLOT_SENT;
                end
                SLOT_SENT: begin
                    if (own_hit) state <= SLOT_FREE;
                end
                default: state <= SLOT_FREE;
            endcase
        end
    end

    // Status seen by the pickers
    always_comb begin
        busy     = (state != SLOT_FREE);
        eligible = (state == SLOT_HELD) && a_ok && b_ok;
    end

    AST_LAUNCH_NEEDS_VALUES: assert property (@(posedge clk) disable iff (!rst_n)
        launch |-> (state == SLOT_HELD && a_ok && b_ok)); // R6

    AST_ALLOC_INTO_FREE: assert property (@(posedge clk) disable iff (!rst_n)
        alloc |-> (state == SLOT_FREE)); // R2

    AST_FREED_AFTER_SENT: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(busy) && !$past(flush)) |-> $past(state == SLOT_SENT)); // R8

endmodule

// File: rtl/fp_rsv_station.sv
// Operand wait station for one floating-point execution unit. Issues fill the
// lowest free slot; the lowest eligible slot is sent each cycle; slots free on
// their own result broadcast; flush empties everything.
// Assumes: the execution unit accepts one operation per cycle unconditionally.
module fp_rsv_station
    import rsv_pkg::*;
#(
    parameter int NUM    = DEF_SLOTS,
    parameter int DATA_W = DEF_DATA_W,
    parameter int TAG_W  = DEF_TAG_W,
    parameter int OP_W   = DEF_OP_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic              iss_valid,
    output logic              iss_ready,
    input  logic [OP_W-1:0]   iss_op,
    input  logic              iss_a_rdy,
    input  logic [DATA_W-1:0] iss_a_val,
    input  logic [TAG_W-1:0]  iss_a_tag,
    input  logic              iss_b_rdy,
    input  logic [DATA_W-1:0] iss_b_val,
    input  logic [TAG_W-1:0]  iss_b_tag,
    input  logic [TAG_W-1:0]  iss_dst,
    input  logic              cdb_valid,
    input  logic [TAG_W-1:0]  cdb_tag,
    input  logic [DATA_W-1:0] cdb_data,
    output logic              disp_valid,
    output logic [OP_W-1:0]   disp_op,
    output logic [DATA_W-1:0] disp_a,
    output logic [DATA_W-1:0] disp_b,
    output logic [TAG_W-1:0]  disp_dst
);

    logic [NUM-1:0]    busy_vec, ready_vec, free_grant, launch_vec;
    logic [NUM-1:0]    alloc_vec;
    logic              any_free;
    logic [OP_W-1:0]   s_op  [NUM];
    logic [DATA_W-1:0] s_a   [NUM];
    logic [DATA_W-1:0] s_b   [NUM];
    logic [TAG_W-1:0]  s_dst [NUM];

    // Choose the lowest free slot for an incoming issue
    rsv_prio #(.N(NUM)) u_free_pick (
        .req   (~busy_vec),
        .grant (free_grant),
        .any   (any_free)
    );

    // Choose the lowest eligible slot to send
    rsv_prio #(.N(NUM)) u_send_pick (
        .req   (ready_vec),
        .grant (launch_vec),
        .any   (disp_valid)
    );

    // Issue acceptance; flush drops a same-cycle issue
    always_comb begin
        iss_ready = any_free;
        alloc_vec = (iss_valid && iss_ready && !flush) ? free_grant : '0;
    end

    generate
        for (genvar g = 0; g < NUM; g++) begin : g_slot
            rsv_slot #(.DATA_W(DATA_W), .TAG_W(TAG_W), .OP_W(OP_W)) u_slot (
                .clk       (clk),
                .rst_n     (rst_n),
                .flush     (flush),
                .alloc     (alloc_vec[g]),
                .iss_op    (iss_op),
                .iss_a_rdy (iss_a_rdy),
                .iss_a_val (iss_a_val),
                .iss_a_tag (iss_a_tag),
                .iss_b_rdy (iss_b_rdy),
                .iss_b_val (iss_b_val),
                .iss_b_tag (iss_b_tag),
                .iss_dst   (iss_dst),
                .cdb_valid (cdb_valid),
                .cdb_tag   (cdb_tag),
                .cdb_data  (cdb_data),
                .launch    (launch_vec[g]),
                .busy      (busy_vec[g]),
                .eligible  (ready_vec[g]),
                .op_q      (s_op[g]),
                .a_q       (s_a[g]),
                .b_q       (s_b[g]),
                .dst_q     (s_dst[g])
            );
        end
    endgenerate

    // One-hot select of the sent slot's contents
    always_comb begin
        disp_op  = '0;
        disp_a   = '0;
        disp_b   = '0;
        disp_dst = '0;
        for (int i = 0; i < NUM; i++) begin
            if (launch_vec[i]) begin
                disp_op  = disp_op  | s_op[i];
                disp_a   = disp_a   | s_a[i];
                disp_b   = disp_b   | s_b[i];
                disp_dst = disp_dst | s_dst[i];
            end
        end
    end

    AST_SINGLE_SEND: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(launch_vec)); // R7

    AST_LOWEST_SENT: assert property (@(posedge clk) disable iff (!rst_n)
        disp_valid |-> ((ready_vec & (launch_vec - 1'b1)) == '0)); // R7

    AST_FULL_REFUSES: assert property (@(posedge clk) disable iff (!rst_n)
        (&busy_vec) |-> !iss_ready); // R2

    AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (busy_vec == '0)); // R9

endmodule

// File: tb/fp_rsv_station_tb_top.sv
`timescale 1ns/1ps
module fp_rsv_station_tb_top;

    localparam int DW = 64;
    localparam int TW = 3;
    localparam int OW = 4;

    typedef struct packed {
        logic [OW-1:0] op;
        logic [DW-1:0] a;
        logic [DW-1:0] b;
        logic [TW-1:0] dst;
    } vec_t;

    localparam vec_t VECS [4] = '{
        '{op: 4'h1, a: 64'h3FF0_0000_0000_0000, b: 64'h4000_0000_0000_0000, dst: 3'd0},
        '{op: 4'h2, a: 64'hDEAD_BEEF_0123_4567, b: 64'h0,                   dst: 3'd5},
        '{op: 4'hF, a: 64'hFFFF_FFFF_FFFF_FFFF, b: 64'h8000_0000_0000_0001, dst: 3'd7},
        '{op: 4'h9, a: 64'h0000_0000_0000_0001, b: 64'h7FF0_0000_0000_0000, dst: 3'd3}
    };

    logic          clk = 1'b0;
    logic          rst_n, flush, iss_valid, iss_ready;
    logic [OW-1:0] iss_op;
    logic          iss_a_rdy, iss_b_rdy;
    logic [DW-1:0] iss_a_val, iss_b_val;
    logic [TW-1:0] iss_a_tag, iss_b_tag, iss_dst;
    logic          cdb_valid;
    logic [TW-1:0] cdb_tag;
    logic [DW-1:0] cdb_data;
    logic          disp_valid;
    logic [OW-1:0] disp_op;
    logic [DW-1:0] disp_a, disp_b;
    logic [TW-1:0] disp_dst;

    int checks = 0;
    int errors = 0;
    logic done = 1'b0;

    always #2.5 clk = ~clk;

    fp_rsv_station dut_i (
        .clk(clk), .rst_n(rst_n), .flush(flush),
        .iss_valid(iss_valid), .iss_ready(iss_ready), .iss_op(iss_op),
        .iss_a_rdy(iss_a_rdy), .iss_a_val(iss_a_val), .iss_a_tag(iss_a_tag),
        .iss_b_rdy(iss_b_rdy), .iss_b_val(iss_b_val), .iss_b_tag(iss_b_tag),
        .iss_dst(iss_dst), .cdb_valid(cdb_valid), .cdb_tag(cdb_tag),
        .cdb_data(cdb_data), .disp_valid(disp_valid), .disp_op(disp_op),
        .disp_a(disp_a), .disp_b(disp_b), .disp_dst(disp_dst)
    );

    task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic idle();
        iss_valid = 1'b0; iss_op = '0;
        iss_a_rdy = 1'b0; iss_a_val = '0; iss_a_tag = '0;
        iss_b_rdy = 1'b0; iss_b_val = '0; iss_b_tag = '0;
        iss_dst = '0; cdb_valid = 1'b0; cdb_tag = '0; cdb_data = '0;
        flush = 1'b0;
    endtask

    task automatic issue(input logic [OW-1:0] op, input logic ar, input logic [DW-1:0] av,
                         input logic [TW-1:0] at, input logic br, input logic [DW-1:0] bv,
                         input logic [TW-1:0] bt, input logic [TW-1:0] dst);
        iss_valid = 1'b1; iss_op = op;
        iss_a_rdy = ar; iss_a_val = av; iss_a_tag = at;
        iss_b_rdy = br; iss_b_val = bv; iss_b_tag = bt;
        iss_dst = dst;
    endtask

    task automatic bcast(input logic [TW-1:0] t, input logic [DW-1:0] d);
        cdb_valid = 1'b1; cdb_tag = t; cdb_data = d;
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            finish_run();
        end
    end

    initial begin
        idle();
        rst_n = 1'b0;
        @(negedge clk); step();
        rst_n = 1'b1;
        // R1: reset state
        chk("R1 iss_ready", iss_ready, 1);
        chk("R1 disp_valid", disp_valid, 0);

        // R3 and R8: table of ready-operand issues, dispatch, then release
        for (int k = 0; k < 4; k++) begin
            issue(VECS[k].op, 1, VECS[k].a, 0, 1, VECS[k].b, 0, VECS[k].dst);
            step(); idle();
            chk("R3 disp_valid", disp_valid, 1);
            chk("R3 disp_op", disp_op, VECS[k].op);
            chk("R3 disp_a", disp_a, VECS[k].a);
            chk("R3 disp_b", disp_b, VECS[k].b);
            chk("R3 disp_dst", disp_dst, VECS[k].dst);
            step();
            chk("R8 no resend", disp_valid, 0);
            bcast(VECS[k].dst, 64'h55);
            step(); idle();
            chk("R8 freed", iss_ready, 1);
        end

        // R2/R4/R6/R7: fill the pool with slots waiting on tag 5
        issue(4'h1, 0, 0, 3'd5, 1, 64'h10, 0, 3'd0); step();
        issue(4'h2, 0, 0, 3'd5, 1, 64'h11, 0, 3'd1); step();
        issue(4'h3, 0, 0, 3'd5, 1, 64'h12, 0, 3'd2); step();
        idle();
        chk("R2 full", iss_ready, 0);
        chk("R6 waiting", disp_valid, 0);
        issue(4'h4, 1, 64'h99, 0, 1, 64'h98, 0, 3'd3); step(); idle();
        chk("R6 still waiting", disp_valid, 0);
        bcast(3'd6, 64'hBAD); step(); idle();
        chk("R4 other tag ignored", disp_valid, 0);
        bcast(3'd5, 64'hC0FFEE); step(); idle();
        chk("R4 captured", disp_valid, 1);
        chk("R7 lowest first", disp_dst, 0);
        chk("R4 value", disp_a, 64'hC0FFEE);
        chk("R4 b kept", disp_b, 64'h10);
        step();
        chk("R7 second", disp_dst, 1);
        chk("R7 second b", disp_b, 64'h11);
        step();
        chk("R7 third", disp_dst, 2);
        step();
        chk("R2 refused issue never sent", disp_valid, 0);
        bcast(3'd6, 0); step(); idle();
        chk("R8 other tag keeps slot", iss_ready, 0);
        bcast(3'd1, 0); step(); idle();
        chk("R8 own tag frees", iss_ready, 1);
        issue(4'h7, 1, 64'h33, 0, 1, 64'h44, 0, 3'd3); step(); idle();
        chk("R8 reuse", disp_dst, 3);
        chk("R8 reuse a", disp_a, 64'h33);
        step();
        bcast(3'd0, 0); step();
        bcast(3'd2, 0); step();
        bcast(3'd3, 0); step(); idle();

        // R5: bypass of a same-cycle broadcast at issue
        issue(4'h5, 0, 0, 3'd4, 1, 64'h77, 0, 3'd4);
        bcast(3'd4, 64'hABC);
        step(); idle();
        chk("R5 bypass valid", disp_valid, 1);
        chk("R5 bypass value", disp_a, 64'hABC);
        step();
        bcast(3'd4, 0); step(); idle();

        // R9: flush empties a full pool
        issue(4'h1, 0, 0, 3'd7, 0, 0, 3'd7, 3'd0); step();
        issue(4'h1, 0, 0, 3'd7, 1, 1, 0, 3'd1); step();
        issue(4'h1, 1, 2, 0, 0, 0, 3'd7, 3'd2); step();
        idle();
        chk("R9 pre full", iss_ready, 0);
        flush = 1'b1; step(); idle();
        chk("R9 emptied", iss_ready, 1);
        bcast(3'd7, 64'h1); step(); idle();
        chk("R9 no stale send", disp_valid, 0);
        step();
        chk("R9 still idle", disp_valid, 0);

        done = 1'b1;
        finish_run();
    end

endmodule